// File: doc/BRIEF.md
# Flash Status-Polling Completion Checker

This block sits on the host side of a parallel flash bus. A program or erase command has already been written to the device, and this block then finds out whether the operation finished. A one-cycle start pulse gives it a polling address and the value that status bit 7 should finally show. For a program, that value is the programmed datum's bit 7. For an erase, it is 1, because erased cells read back as all ones. The block then issues read cycles at that address and judges status bit 7 and status bit 5 of each returned byte. It ends with a one-cycle done pulse and a pass flag.

Bit 7 can settle at a different moment from the other data bits. It can also flip in the same read in which bit 5 (the device's time-limit flag) first shows 1. For this reason, a set bit 5 never fails the operation on its own: the block makes one more fresh read and tests bit 7 again. A bounded poll budget turns a device that never raises bit 5 into a fail result, so the block cannot hang.

Top module: `flash_poll_ctrl`

## Requirements
- R1: Every read cycle of an operation presents the address latched at start. The address stays stable while the read strobe is high. A start pulse that arrives while an operation is in progress is ignored and changes neither the address nor the result.
- R2: Each read cycle holds `bus_rd_o` high for exactly RD_LAT consecutive cycles. The returned byte is sampled at the clock edge that ends the last high cycle.
- R3: If bit 7 of a read equals the expected value, the result is pass. For a program the expected value is the datum's bit 7; for an erase it is 1. When this happens on the first read, the operation uses exactly one read.
- R4: If bit 7 differs and bit 5 (value 0x20) is 0, the block issues another read at the same address.
- R5: If bit 7 differs and bit 5 is 1, the block issues exactly one more read. The result is pass only if bit 7 of that second read matches.
- R6: When MAX_POLLS is not zero, the block fails after MAX_POLLS consecutive first-stage reads that each show a bit-7 mismatch with bit 5 clear. It issues no further read.
- R7: `done_o` is high for exactly one cycle per operation. `pass_o` keeps the result from that cycle until the next accepted start, which clears it.
- R8: After reset, `bus_rd_o`, `done_o` and `pass_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin polling |
| poll_addr_i | input | ADDR_W | Valid polling address, sampled with start |
| expect_d7_i | input | 1 | Final expected value of status bit 7 |
| bus_addr_o | output | ADDR_W | Read address to the flash bus |
| bus_rd_o | output | 1 | Read strobe |
| bus_rdata_i | input | 8 | Byte returned by the device |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Result, held until the next start |

## Verification
The bench builds, for each operation, a list of status bytes that the device returns on successive reads. From that list it predicts both the result and the exact number of reads. Corner cases:
- A bit-5 read whose bit 7 flips in the following read. A design that failed at once on bit 5 would report fail here.
- A bit-5 read followed by a mismatch. A design that looped forever would hang here.
- A device that never raises bit 5. A design with a broken budget would either read past MAX_POLLS or stop early.
- A start pulse sent mid-run. A design that accepted it would move the address or clear the flag.
- Strobe width and address per read. An off-by-one latency counter would sample one cycle early or late.

// File: rtl/poll_pkg.sv
package poll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ1  = 3'd1,
    ST_CHECK7 = 3'd2,
    ST_CHECK5 = 3'd3,
    ST_READ2  = 3'd4,
    ST_RECHK7 = 3'd5,
    ST_DONE   = 3'd6
  } poll_state_t;

  localparam int unsigned BIT_DONE7 = 7;
  localparam int unsigned BIT_LIMIT = 5;

endpackage

// File: rtl/poll_bus_reader.sv
module poll_bus_reader #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_rd_o,
  input  logic [7:0]        bus_rdata_i,
  output logic              valid_o,
  output logic              b7_o,
  output logic              b5_o
);
  import poll_pkg::*;

  localparam int unsigned CW = (RD_LAT < 2) ? 1 : $clog2(RD_LAT + 1);

  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rd_o   <= 1'b0;
      bus_addr_o <= '0;
      hi_cnt     <= '0;
      valid_o    <= 1'b0;
      b7_o       <= 1'b0;
      b5_o       <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (!bus_rd_o) begin
        if (req_i) begin
          bus_rd_o   <= 1'b1;
          bus_addr_o <= addr_i;
          hi_cnt     <= CW'(1);
        end
      end else if (hi_cnt == CW'(RD_LAT)) begin
        bus_rd_o <= 1'b0;
        valid_o  <= 1'b1;
        b7_o     <= bus_rdata_i[BIT_DONE7];
        b5_o     <= bus_rdata_i[BIT_LIMIT];
      end else begin
        hi_cnt <= hi_cnt + CW'(1);
      end
    end
  end

endmodule

// File: rtl/poll_budget.sv
module poll_budget #(
  parameter int unsigned MAX_POLLS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CW = (MAX_POLLS < 2) ? 1 : $clog2(MAX_POLLS);

  logic [CW-1:0] used;

  always_ff @(posedge clk) begin
    if (rst || clr_i) used <= '0;
    else if (inc_i)   used <= used + CW'(1);
  end

  generate
    if (MAX_POLLS == 0) begin : g_unbounded
      assign last_o = 1'b0;
    end else begin : g_bounded
      assign last_o = (used == CW'(MAX_POLLS - 1));
    end
  endgenerate

endmodule

// File: rtl/poll_seq_fsm.sv
module poll_seq_fsm #(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              expect_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic              rd_b7_i,
  input  logic              rd_b5_i,
  output logic              bud_clr_o,
  output logic              bud_inc_o,
  input  logic              bud_last_i,
  output logic              done_o,
  output logic              pass_o
);
  import poll_pkg::*;

  poll_state_t state;
  logic        exp_q;
  logic        s7_q;
  logic        s5_q;

  assign bud_clr_o = (state == ST_IDLE) && start_i;
  assign bud_inc_o = (state == ST_CHECK5) && !s5_q && !bud_last_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rd_req_o  <= 1'b0;
      rd_addr_o <= '0;
      exp_q     <= 1'b0;
      s7_q      <= 1'b0;
      s5_q      <= 1'b0;
      done_o    <= 1'b0;
      pass_o    <= 1'b0;
    end else begin
      rd_req_o <= 1'b0;
      done_o   <= 1'b0;
      unique case (state)
        ST_IDLE: if (start_i) begin
          rd_addr_o <= addr_i;
          exp_q     <= expect_i;
          pass_o    <= 1'b0;
          rd_req_o  <= 1'b1;
          state     <= ST_READ1;
        end
        ST_READ1: if (rd_valid_i) begin
          s7_q  <= rd_b7_i;
          s5_q  <= rd_b5_i;
          state <= ST_CHECK7;
        end
        ST_CHECK7: begin
          if (s7_q == exp_q) begin
            pass_o <= 1'b1;
            done_o <= 1'b1;
            state  <= ST_DONE;
          end else begin
            state <= ST_CHECK5;
          end
        end
        ST_CHECK5: begin
          if (s5_q) begin
            rd_req_o <= 1'b1;
            state    <= ST_READ2;
          end else if (bud_last_i) begin
            pass_o <= 1'b0;
            done_o <= 1'b1;
            state  <= ST_DONE;
          end else begin
            rd_req_o <= 1'b1;
            state    <= ST_READ1;
          end
        end
        ST_READ2: if (rd_valid_i) begin
          s7_q  <= rd_b7_i;
          s5_q  <= rd_b5_i;
          state <= ST_RECHK7;
        end
        ST_RECHK7: begin
          pass_o <= (s7_q == exp_q);
          done_o <= 1'b1;
          state  <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl #(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned RD_LAT    = 2,
  parameter int unsigned MAX_POLLS = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] poll_addr_i,
  input  logic              expect_d7_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_rd_o,
  input  logic [7:0]        bus_rdata_i,
  output logic              done_o,
  output logic              pass_o
);

  logic              rd_req;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_valid;
  logic              rd_b7;
  logic              rd_b5;
  logic              bud_clr;
  logic              bud_inc;
  logic              bud_last;

  poll_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .addr_i     (poll_addr_i),
    .expect_i   (expect_d7_i),
    .rd_req_o   (rd_req),
    .rd_addr_o  (rd_addr),
    .rd_valid_i (rd_valid),
    .rd_b7_i    (rd_b7),
    .rd_b5_i    (rd_b5),
    .bud_clr_o  (bud_clr),
    .bud_inc_o  (bud_inc),
    .bud_last_i (bud_last),
    .done_o     (done_o),
    .pass_o     (pass_o)
  );

  poll_bus_reader #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_reader (
    .clk         (clk),
    .rst         (rst),
    .req_i       (rd_req),
    .addr_i      (rd_addr),
    .bus_addr_o  (bus_addr_o),
    .bus_rd_o    (bus_rd_o),
    .bus_rdata_i (bus_rdata_i),
    .valid_o     (rd_valid),
    .b7_o        (rd_b7),
    .b5_o        (rd_b5)
  );

  poll_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (bud_clr),
    .inc_i  (bud_inc),
    .last_o (bud_last)
  );

endmodule

// File: rtl/flash_poll_ctrl_chk.sv
module flash_poll_ctrl_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned RD_LAT = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_rd_o,
  input logic              done_o,
  input logic              pass_o
);
  logic [15:0] hi_seen;

  always_ff @(posedge clk) begin
    if (rst)           hi_seen <= '0;
    else if (bus_rd_o) hi_seen <= hi_seen + 16'd1;
    else               hi_seen <= '0;
  end

  // R2
  strobe_len_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd_o |-> (hi_seen < 16'(RD_LAT)));

  // R2
  strobe_min_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd_o && hi_seen != 16'd0) |-> (hi_seen == 16'(RD_LAT)));

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_o && hi_seen != 16'd0) |-> $stable(bus_addr_o));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7
  pass_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pass_o) |-> done_o);

  // R6
  no_read_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !bus_rd_o);

endmodule

bind flash_poll_ctrl flash_poll_ctrl_chk #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr_o (bus_addr_o),
  .bus_rd_o   (bus_rd_o),
  .done_o     (done_o),
  .pass_o     (pass_o)
);

// File: tb/flash_poll_ctrl_bench.sv
module flash_poll_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 16;
  localparam int LAT = 3;
  localparam int MAXP = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [AW-1:0] poll_addr_i = '0;
  logic          expect_d7_i = 1'b0;
  logic [AW-1:0] bus_addr_o;
  logic          bus_rd_o;
  logic [7:0]    bus_rdata_i;
  logic          done_o;
  logic          pass_o;

  int checks = 0;
  int errors = 0;

  logic [7:0]    seq [16];
  int            n_reads = 0;
  logic          rd_q = 1'b0;
  int            hi_len = 0;
  logic [AW-1:0] cur_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus_rdata_i = seq[(n_reads > 15) ? 15 : n_reads];

  flash_poll_ctrl #(.ADDR_W(AW), .RD_LAT(LAT), .MAX_POLLS(MAXP)) u_flash_poll_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .poll_addr_i(poll_addr_i),
    .expect_d7_i(expect_d7_i), .bus_addr_o(bus_addr_o), .bus_rd_o(bus_rd_o),
    .bus_rdata_i(bus_rdata_i), .done_o(done_o), .pass_o(pass_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // bus monitor: address (R1) and strobe width (R2) per read
  always @(posedge clk) begin
    rd_q <= bus_rd_o;
    if (bus_rd_o) begin
      if (!rd_q) check(bus_addr_o == cur_addr, "R1 addr", int'(bus_addr_o), int'(cur_addr));
      hi_len <= hi_len + 1;
    end else begin
      if (rd_q) begin
        check(hi_len == LAT, "R2 strobe", hi_len, LAT);
        n_reads <= n_reads + 1;
      end
      hi_len <= 0;
    end
  end

  function automatic void model(input bit e, output bit p, output int reads);
    int polls = 0;
    reads = 0;
    p = 1'b0;
    while (1) begin
      logic [7:0] b = seq[reads];
      reads++;
      if (b[7] == e) begin p = 1'b1; return; end
      if (!b[5]) begin
        polls++;
        if (polls == MAXP) begin p = 1'b0; return; end
      end else begin
        p = (seq[reads][7] == e);
        reads++;
        return;
      end
    end
  endfunction

  task automatic run_op(input logic [AW-1:0] a, input bit e, input bit poke, input string tag);
    bit exp_p;
    int exp_r;
    int waited = 0;
    model(e, exp_p, exp_r);
    @(negedge clk);
    n_reads     = 0;
    cur_addr    = a;
    poll_addr_i = a;
    expect_d7_i = e;
    start_i     = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      poll_addr_i = ~a;
      expect_d7_i = ~e;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o && waited < 1000) begin
      @(negedge clk);
      waited++;
    end
    check(done_o == 1'b1, {tag, " done"}, int'(done_o), 1);
    check(pass_o == exp_p, {tag, " result"}, int'(pass_o), int'(exp_p));
    check(n_reads == exp_r, {tag, " reads"}, n_reads, exp_r);
    @(negedge clk);
    // R7 pulse width and hold
    check(done_o == 1'b0, "R7 done width", int'(done_o), 0);
    repeat (3) @(negedge clk);
    check(pass_o == exp_p && !bus_rd_o, "R7 hold", int'(pass_o), int'(exp_p));
  endtask

  function automatic logic [7:0] rbyte(input bit e, input int bias);
    logic [7:0] b = 8'($urandom);
    b[7] = (($urandom % 100) < bias) ? e : ~e;
    b[5] = (($urandom % 100) < 20);
    return b;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) seq[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(!bus_rd_o && !done_o && !pass_o, "R8 reset", int'({bus_rd_o, done_o, pass_o}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!bus_rd_o && !done_o && !pass_o, "R8 idle", int'({bus_rd_o, done_o, pass_o}), 0);

    // R3 program, first read matches (bit7 = 0)
    seq[0] = 8'h12;
    run_op(16'h0101, 1'b0, 1'b0, "R3 prog");
    // R3 erase: expected 1, erased byte
    seq[0] = 8'h00; seq[1] = 8'h00; seq[2] = 8'hFF;
    run_op(16'h2000, 1'b1, 1'b0, "R3 R4 erase");
    // R5 bit5 set, bit7 flips on reread
    seq[0] = 8'h20; seq[1] = 8'hA0;
    run_op(16'h0033, 1'b1, 1'b0, "R5 recover");
    // R5 bit5 set, still mismatch
    seq[0] = 8'h04; seq[1] = 8'h20; seq[2] = 8'h20; seq[3] = 8'h80;
    run_op(16'h0044, 1'b1, 1'b0, "R5 fail");
    // R6 budget exhausted
    for (int i = 0; i < 16; i++) seq[i] = 8'h5F;
    run_op(16'h0777, 1'b1, 1'b0, "R6 budget");
    // R1 start ignored while busy
    seq[0] = 8'h00; seq[1] = 8'h00; seq[2] = 8'h00; seq[3] = 8'h80;
    run_op(16'h1234, 1'b1, 1'b1, "R1 busy start");

    for (int k = 0; k < 40; k++) begin
      bit e = 1'($urandom);
      for (int i = 0; i < 16; i++) seq[i] = rbyte(e, 25);
      run_op(AW'($urandom), e, 1'($urandom % 4 == 0), "R4 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule